// File: doc/BRIEF.md
# CPU Address-Space Decoder with Work-RAM Banking

This block sits between a CPU bus with 16-bit addresses and 8-bit data and the memories and peripherals behind it. For every read or write it raises one select line that names the target: cartridge, video unit, work RAM, boot ROM, peripheral I/O, high RAM, or the decoder's own local responder. For work-RAM accesses it also produces the local work-RAM byte address. For boot-ROM reads it passes on the boot-ROM byte address. When the local responder is selected, it supplies the read byte itself.

The decoder owns two pieces of state. The first is a boot flag. While the flag is set, a boot ROM overlays the bottom of the cartridge space for reads. The flag can be cleared but never set again. The second is a work-RAM bank number that picks which 4 KB bank appears in the upper half of the work-RAM window. In colour mode the boot overlay is larger and leaves a hole where the cartridge header shows through. The work-RAM mirror above the work-RAM window always uses the fixed layout and ignores the bank number. Unused addresses read a constant. An access to an I/O address that nothing decodes also gives a one-cycle flag.

Top module: `memmap_decoder`

## Requirements
- R1: When busRd or busWr is high, exactly one bit of targetSel is set. When neither is high, targetSel is zero. Bit encoding: 0 cartridge, 1 video, 2 work RAM, 3 boot ROM, 4 I/O, 5 high RAM, 6 local.
- R2: After reset the boot flag is set and the bank number is 1. A read of 0xFF50 returns 0x00 and a read of 0xFF70 returns 0xF9.
- R3: While the boot flag is set, reads of 0x0000–0x00FF select the boot ROM, with bootAddr equal to addr[11:0]. Writes to that range select the cartridge.
- R4: In colour mode with the boot flag set, reads of 0x0200–0x08FF also select the boot ROM. Reads of 0x0100–0x01FF and 0x0900 and above select the cartridge. In legacy mode only 0x0000–0x00FF is overlaid.
- R5: Writing a nonzero byte to 0xFF50 clears the boot flag, and it then stays clear. Writing 0x00 has no effect. A read of 0xFF50 returns 0x01 when the flag is clear and 0x00 when it is set.
- R6: Addresses 0xC000–0xCFFF give wramAddr = addr[11:0]. Addresses 0xD000–0xDFFF give wramAddr = bank·0x1000 + addr[11:0] in colour mode, and 0x1000 + addr[11:0] in legacy mode.
- R7: A write to 0xFF70 loads data[2:0] into the bank, and a value of 0 is stored as 1. A read of 0xFF70 returns 0xF8 | bank.
- R8: Addresses 0xE000–0xFDFF select work RAM with wramAddr = addr[12:0], whatever the bank number.
- R9: Addresses 0xFEA0–0xFEFF and 0xFF56 select local, read as 0xFF, and change no state when written.
- R10: Addresses 0x0000–0x7FFF (outside the overlay) and 0xA000–0xBFFF select the cartridge. Addresses 0x8000–0x9FFF, 0xFE00–0xFE9F, 0xFF40–0xFF45, 0xFF47–0xFF4B, 0xFF4F and 0xFF68–0xFF6B select video. Addresses 0xFF80–0xFFFE select high RAM. Addresses 0xFF46 and 0xFFFF select I/O.
- R11: An access to an I/O address that no target decodes (for example 0xFF03) selects local and reads 0xFF. In the cycle after that access, unmappedPulse is high for one cycle. A decoded access gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| colorMode | input | 1 | 1 = colour mode, 0 = legacy mode |
| busAddr | input | 16 | CPU address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| targetSel | output | 7 | One-hot target select |
| wramAddr | output | 15 | Work-RAM byte address |
| bootAddr | output | 12 | Boot-ROM byte address |
| localRdata | output | 8 | Read data from the local responder |
| unmappedPulse | output | 1 | One-cycle flag after an undecoded I/O access |

## Verification
The table sweeps both modes across the region edges. Reading the same low address in legacy and in colour mode shows whether the boot overlay is sized by mode. Reads just inside and just outside the header hole show its limits. The directed part loads several bank values, including 0 and a value with high bits set, then reads the banked window and the mirror window. This tells a correct bank remap apart from a mirror that wrongly follows the bank. The boot flag gets the sequence zero write, nonzero write, zero write to show that the flag only ever clears.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int NUM_TGT   = 7;
  localparam int TGT_CART  = 0;
  localparam int TGT_VIDEO = 1;
  localparam int TGT_WRAM  = 2;
  localparam int TGT_BOOT  = 3;
  localparam int TGT_IO    = 4;
  localparam int TGT_HRAM  = 5;
  localparam int TGT_LOCAL = 6;

  // strobes from the decode control to the state/datapath
  typedef struct packed {
    logic bootOff;
    logic bankWr;
    logic rdBoot;
    logic rdBank;
    logic unmappedHit;
  } mapStb_t;
endpackage

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
  import memmap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               colorMode,
  input  logic               bootActive,
  input  logic [15:0]        busAddr,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [7:0]         busWdata,
  output logic [NUM_TGT-1:0] targetSel,
  output mapStb_t            stb
);
  logic       access;
  logic [7:0] lo;
  logic       ioPage;
  int         tgtIdx;
  logic       undecoded;

  assign access = busRd | busWr;
  assign lo     = busAddr[7:0];
  assign ioPage = (busAddr[15:8] == 8'hFF);

  always_comb begin
    tgtIdx    = TGT_LOCAL;
    undecoded = 1'b0;
    if (busAddr <= 16'h7FFF) begin
      if (busRd && bootActive &&
          (busAddr[15:8] == 8'h00 ||
           (colorMode && busAddr >= 16'h0200 && busAddr <= 16'h08FF)))
        tgtIdx = TGT_BOOT;
      else
        tgtIdx = TGT_CART;
    end else if (busAddr <= 16'h9FFF) tgtIdx = TGT_VIDEO;
    else if (busAddr <= 16'hBFFF)     tgtIdx = TGT_CART;
    else if (busAddr <= 16'hFDFF)     tgtIdx = TGT_WRAM;
    else if (busAddr <= 16'hFE9F)     tgtIdx = TGT_VIDEO;
    else if (!ioPage)                 tgtIdx = TGT_LOCAL;
    else if (lo == 8'hFF)             tgtIdx = TGT_IO;
    else if (lo >= 8'h80)             tgtIdx = TGT_HRAM;
    else if (lo inside {[8'h00:8'h02], [8'h04:8'h07], 8'h0F, [8'h10:8'h26],
                        [8'h30:8'h3F], 8'h46, 8'h4C, 8'h4D, [8'h51:8'h55]})
      tgtIdx = TGT_IO;
    else if (lo inside {[8'h40:8'h45], [8'h47:8'h4B], 8'h4F, [8'h68:8'h6B]})
      tgtIdx = TGT_VIDEO;
    else if (lo inside {8'h50, 8'h56, 8'h70})
      tgtIdx = TGT_LOCAL;
    else begin
      tgtIdx    = TGT_LOCAL;
      undecoded = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_TGT; i++)
      targetSel[i] = access && (tgtIdx == i);
  end

  always_comb begin
    stb.bootOff     = busWr && ioPage && lo == 8'h50 && busWdata != 8'h00;
    stb.bankWr      = busWr && ioPage && lo == 8'h70;
    stb.rdBoot      = ioPage && lo == 8'h50;
    stb.rdBank      = ioPage && lo == 8'h70;
    stb.unmappedHit = access && undecoded;
  end

  // R1
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    access |-> $onehot(targetSel));
  // R1
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !access |-> targetSel == '0);
  // R11
  unmapped_local_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.unmappedHit |-> targetSel[TGT_LOCAL]);
  // R3
  boot_rd_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> !targetSel[TGT_BOOT]);
endmodule

// File: rtl/memmap_data.sv
module memmap_data
  import memmap_pkg::*;
#(
  parameter int BANK_W  = 3,
  parameter int BOOT_AW = 12,
  localparam int WRAM_AW = 12 + BANK_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               colorMode,
  input  logic [15:0]        busAddr,
  input  logic [BANK_W-1:0]  bankData,
  input  mapStb_t            stb,
  output logic               bootActive,
  output logic [WRAM_AW-1:0] wramAddr,
  output logic [BOOT_AW-1:0] bootAddr,
  output logic [7:0]         localRdata,
  output logic               unmappedPulse
);
  logic [BANK_W-1:0] bank;
  logic [BANK_W-1:0] effBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bank          <= BANK_W'(1);
      bootActive    <= 1'b1;
      unmappedPulse <= 1'b0;
    end else begin
      if (stb.bankWr)
        bank <= (bankData == '0) ? BANK_W'(1) : bankData;
      if (stb.bootOff)
        bootActive <= 1'b0;
      unmappedPulse <= stb.unmappedHit;
    end
  end

  assign effBank = colorMode ? bank : BANK_W'(1);

  always_comb begin
    case (busAddr[15:12])
      4'hC:    wramAddr = {{BANK_W{1'b0}}, busAddr[11:0]};
      4'hD:    wramAddr = {effBank, busAddr[11:0]};
      default: wramAddr = {{(WRAM_AW-13){1'b0}}, busAddr[12:0]};
    endcase
  end

  assign bootAddr = BOOT_AW'(busAddr[11:0]);

  always_comb begin
    if (stb.rdBoot)      localRdata = {7'b0, ~bootActive};
    else if (stb.rdBank) localRdata = 8'hFF & {{(8-BANK_W){1'b1}}, bank};
    else                 localRdata = 8'hFF;
  end

  // R7
  bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    bank != '0);
  // R7
  bank_zero_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.bankWr && bankData == '0) |=> bank == BANK_W'(1));
  // R5
  boot_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bootActive |=> !bootActive);
  // R8
  echo_unbanked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= 16'hE000 && busAddr <= 16'hFDFF) |-> wramAddr[WRAM_AW-1:13] == '0);
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int BANK_W  = 3,
  parameter int BOOT_AW = 12,
  localparam int WRAM_AW = 12 + BANK_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               colorMode,
  input  logic [15:0]        busAddr,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [7:0]         busWdata,
  output logic [NUM_TGT-1:0] targetSel,
  output logic [WRAM_AW-1:0] wramAddr,
  output logic [BOOT_AW-1:0] bootAddr,
  output logic [7:0]         localRdata,
  output logic               unmappedPulse
);
  mapStb_t stb;
  logic    bootActive;

  memmap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .colorMode(colorMode), .bootActive(bootActive),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .targetSel(targetSel), .stb(stb)
  );

  memmap_data #(.BANK_W(BANK_W), .BOOT_AW(BOOT_AW)) u_data (
    .clk(clk), .rstN(rstN), .colorMode(colorMode), .busAddr(busAddr),
    .bankData(busWdata[BANK_W-1:0]), .stb(stb), .bootActive(bootActive),
    .wramAddr(wramAddr), .bootAddr(bootAddr), .localRdata(localRdata),
    .unmappedPulse(unmappedPulse)
  );
endmodule

// File: tb/sim_memmap_decoder.sv
module sim_memmap_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        colorMode = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [6:0]  targetSel;
  logic [14:0] wramAddr;
  logic [11:0] bootAddr;
  logic [7:0]  localRdata;
  logic        unmappedPulse;

  int nChk = 0;
  int nErr = 0;

  always #5 clk = ~clk;

  memmap_decoder u0 (
    .clk(clk), .rstN(rstN), .colorMode(colorMode), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .targetSel(targetSel),
    .wramAddr(wramAddr), .bootAddr(bootAddr), .localRdata(localRdata),
    .unmappedPulse(unmappedPulse)
  );

  localparam logic [6:0] CART = 7'h01, VID = 7'h02, WRAM = 7'h04, BOOT = 7'h08,
                         IO = 7'h10, HRAM = 7'h20, LOC = 7'h40;

  // {colour, addr, expected select, expected wram addr, expected local data}
  localparam int NV = 31;
  localparam logic [46:0] VEC [0:NV-1] = '{
    {1'b0, 16'h0050, BOOT, 15'h0, 8'h00},   // R3
    {1'b0, 16'h0150, CART, 15'h0, 8'h00},   // R4
    {1'b0, 16'h0300, CART, 15'h0, 8'h00},   // R4 legacy: no big overlay
    {1'b1, 16'h0300, BOOT, 15'h0, 8'h00},   // R4
    {1'b1, 16'h0150, CART, 15'h0, 8'h00},   // R4 header hole
    {1'b1, 16'h01FF, CART, 15'h0, 8'h00},   // R4
    {1'b1, 16'h0200, BOOT, 15'h0, 8'h00},   // R4
    {1'b1, 16'h08FF, BOOT, 15'h0, 8'h00},   // R4
    {1'b1, 16'h0900, CART, 15'h0, 8'h00},   // R4
    {1'b1, 16'h7FFF, CART, 15'h0, 8'h00},   // R10
    {1'b1, 16'hA000, CART, 15'h0, 8'h00},   // R10
    {1'b1, 16'hBFFF, CART, 15'h0, 8'h00},   // R10
    {1'b1, 16'h8000, VID,  15'h0, 8'h00},   // R10
    {1'b1, 16'hFE9F, VID,  15'h0, 8'h00},   // R10
    {1'b1, 16'hFF40, VID,  15'h0, 8'h00},   // R10
    {1'b1, 16'hFF4F, VID,  15'h0, 8'h00},   // R10
    {1'b1, 16'hFF6B, VID,  15'h0, 8'h00},   // R10
    {1'b1, 16'hFF46, IO,   15'h0, 8'h00},   // R10
    {1'b1, 16'hFFFF, IO,   15'h0, 8'h00},   // R10
    {1'b1, 16'hFF80, HRAM, 15'h0, 8'h00},   // R10
    {1'b1, 16'hFFFE, HRAM, 15'h0, 8'h00},   // R10
    {1'b1, 16'hC123, WRAM, 15'h0123, 8'h00},// R6
    {1'b1, 16'hD456, WRAM, 15'h1456, 8'h00},// R6
    {1'b1, 16'hE789, WRAM, 15'h0789, 8'h00},// R8
    {1'b1, 16'hF234, WRAM, 15'h1234, 8'h00},// R8
    {1'b1, 16'hFDFF, WRAM, 15'h1DFF, 8'h00},// R8
    {1'b1, 16'hFEA0, LOC,  15'h0, 8'hFF},   // R9
    {1'b1, 16'hFEFF, LOC,  15'h0, 8'hFF},   // R9
    {1'b1, 16'hFF56, LOC,  15'h0, 8'hFF},   // R9
    {1'b1, 16'hFF50, LOC,  15'h0, 8'h00},   // R2
    {1'b1, 16'hFF70, LOC,  15'h0, 8'hF9}    // R2
  };

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic col, input logic [15:0] a, input logic rd,
                     input logic wr, input logic [7:0] d);
    @(negedge clk);
    colorMode = col; busAddr = a; busRd = rd; busWr = wr; busWdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0;
    #1;
  endtask

  initial begin
    #1_000_000;
    nErr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    chk("R1 idle", int'(targetSel), 0);
    chk("R2 pulse", int'(unmappedPulse), 0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][46], VEC[i][45:30], 1'b1, 1'b0, 8'h00);
      chk($sformatf("R1/R10 sel @%h", VEC[i][45:30]), int'(targetSel), int'(VEC[i][29:23]));
      if (VEC[i][29:23] == WRAM)
        chk($sformatf("R6/R8 wram @%h", VEC[i][45:30]), int'(wramAddr), int'(VEC[i][22:8]));
      if (VEC[i][29:23] == LOC)
        chk($sformatf("R2/R9 data @%h", VEC[i][45:30]), int'(localRdata), int'(VEC[i][7:0]));
      if (VEC[i][29:23] == BOOT)
        chk("R3 bootAddr", int'(bootAddr), int'(VEC[i][41:30]));
    end

    // R3: writes into the overlay go to the cartridge
    acc(1'b1, 16'h0050, 1'b0, 1'b1, 8'h12);
    chk("R3 write to cart", int'(targetSel), int'(CART));

    // R7 bank load and read-back
    acc(1'b1, 16'hFF70, 1'b0, 1'b1, 8'h03);
    acc(1'b1, 16'hFF70, 1'b1, 1'b0, 8'h00);
    chk("R7 read bank 3", int'(localRdata), 8'hFB);
    acc(1'b1, 16'hD010, 1'b1, 1'b0, 8'h00);
    chk("R6 banked 3", int'(wramAddr), 15'h3010);
    acc(1'b1, 16'hF010, 1'b1, 1'b0, 8'h00);
    chk("R8 echo ignores bank", int'(wramAddr), 15'h1010);
    acc(1'b1, 16'hC010, 1'b1, 1'b0, 8'h00);
    chk("R6 fixed bank", int'(wramAddr), 15'h0010);
    acc(1'b1, 16'hFF70, 1'b0, 1'b1, 8'h00);
    acc(1'b1, 16'hFF70, 1'b1, 1'b0, 8'h00);
    chk("R7 zero becomes one", int'(localRdata), 8'hF9);
    acc(1'b1, 16'hFF70, 1'b0, 1'b1, 8'h0D);
    acc(1'b1, 16'hDFFF, 1'b1, 1'b0, 8'h00);
    chk("R7 low bits only", int'(wramAddr), 15'h5FFF);
    acc(1'b0, 16'hD010, 1'b1, 1'b0, 8'h00);
    chk("R6 legacy bank fixed", int'(wramAddr), 15'h1010);

    // R9 writes to unusable addresses change nothing
    acc(1'b1, 16'hFF56, 1'b0, 1'b1, 8'h00);
    acc(1'b1, 16'hFEA0, 1'b0, 1'b1, 8'h00);
    acc(1'b1, 16'hFF70, 1'b1, 1'b0, 8'h00);
    chk("R9 bank kept", int'(localRdata), 8'hFD);
    acc(1'b1, 16'hFEA0, 1'b1, 1'b0, 8'h00);
    chk("R9 still FF", int'(localRdata), 8'hFF);
    acc(1'b1, 16'hFF56, 1'b0, 1'b1, 8'h01);
    acc(1'b1, 16'h0050, 1'b1, 1'b0, 8'h00);
    chk("R9 boot kept", int'(targetSel), int'(BOOT));

    // R11 undecoded I/O
    acc(1'b1, 16'hFF03, 1'b1, 1'b0, 8'h00);
    chk("R11 sel local", int'(targetSel), int'(LOC));
    chk("R11 data FF", int'(localRdata), 8'hFF);
    idle();
    chk("R11 pulse", int'(unmappedPulse), 1);
    chk("R1 idle sel", int'(targetSel), 0);
    idle();
    chk("R11 pulse ends", int'(unmappedPulse), 0);
    acc(1'b1, 16'hFF46, 1'b1, 1'b0, 8'h00);
    idle();
    chk("R11 no pulse mapped", int'(unmappedPulse), 0);
    acc(1'b1, 16'hFF71, 1'b0, 1'b1, 8'h00);
    idle();
    chk("R11 pulse on write", int'(unmappedPulse), 1);

    // R5 boot flag
    acc(1'b1, 16'hFF50, 1'b0, 1'b1, 8'h00);
    acc(1'b1, 16'h0050, 1'b1, 1'b0, 8'h00);
    chk("R5 zero keeps boot", int'(targetSel), int'(BOOT));
    acc(1'b1, 16'hFF50, 1'b1, 1'b0, 8'h00);
    chk("R5 read active", int'(localRdata), 0);
    acc(1'b1, 16'hFF50, 1'b0, 1'b1, 8'h80);
    acc(1'b1, 16'h0050, 1'b1, 1'b0, 8'h00);
    chk("R5 boot off", int'(targetSel), int'(CART));
    acc(1'b1, 16'h0300, 1'b1, 1'b0, 8'h00);
    chk("R5 colour overlay off", int'(targetSel), int'(CART));
    acc(1'b1, 16'hFF50, 1'b1, 1'b0, 8'h00);
    chk("R5 read inactive", int'(localRdata), 1);
    acc(1'b1, 16'hFF50, 1'b0, 1'b1, 8'h00);
    acc(1'b1, 16'h0050, 1'b1, 1'b0, 8'h00);
    chk("R5 sticky", int'(targetSel), int'(CART));

    // R2 reset restores state
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    acc(1'b1, 16'hFF70, 1'b1, 1'b0, 8'h00);
    chk("R2 bank after reset", int'(localRdata), 8'hF9);
    acc(1'b1, 16'h0010, 1'b1, 1'b0, 8'h00);
    chk("R2 boot after reset", int'(targetSel), int'(BOOT));
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end
endmodule